// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

This block produces a pulse-width modulated output from an 8-bit period timer. The oscillator clock drives a sub-cycle counter. At a 1:1 prescale the timer advances once every four oscillator clocks, and at the coarser settings it advances once every four times the prescale factor. When the timer reaches the programmed period value, the next increment starts a new period: the timer returns to zero, the output goes high, and the duty value that software has written is copied into an internal active latch.

The duty value is 10 bits wide. Software supplies it as an 8-bit upper part and a separate 2-bit lower part, and may change either at any time. The output goes low when a 10-bit time base equals the active duty value. The time base is the timer with two fine bits from the sub-cycle counter below it. Because the duty value is only copied into the active latch at a rollover, a write in the middle of a period never shortens or stretches the pulse that is already running. A one-cycle pulse marks the first clock of every period, and the upper byte of the active latch is visible on a read-only port.

Top module: `pwm_dbuf`

## Requirements
- R1: The period lasts (period_val + 1) × 4 × k oscillator clocks, where k is the prescale factor chosen by presc_sel: 2'b00 gives k=1, 2'b01 gives k=4, and 2'b10 or 2'b11 gives k=16.
- R2: At each rollover the timer returns to zero, and period_tick is high in the first clock of the new period.
- R3: The active duty value is {duty_hi, duty_lo}, with duty_hi in bits 9..2 and duty_lo in bits 1..0. When this value is D with 0 < D < 4 × (period_val + 1), pwm_out is high for exactly D × k clocks, starting with the first clock of the period.
- R4: A duty value that is written takes effect only at the next rollover. duty_active_hi shows bits 9..2 of the active latch and changes only at a rollover.
- R5: An active duty value of zero keeps pwm_out low for the whole period.
- R6: An active duty value of 4 × (period_val + 1) or more keeps pwm_out high for the whole period.
- R7: While rst_n is low, pwm_out, period_tick and duty_active_hi are all zero.
- R8: While en is low, pwm_out and period_tick stay low and the timer holds at zero. After en rises, the first period is (period_val + 1) × 4 × k clocks long with pwm_out low, because no duty value has been latched yet.
- R9: period_tick is never high in two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Run enable; when low the timer holds at zero and the output is low |
| presc_sel | input | 2 | Prescale select: 00 = 1:1, 01 = 1:4, 1x = 1:16 |
| period_val | input | 8 | Timer value at which the period ends |
| duty_hi | input | 8 | Upper eight bits of the pending duty value |
| duty_lo | input | 2 | Lower two bits of the pending duty value |
| pwm_out | output | 1 | Modulated output |
| duty_active_hi | output | 8 | Upper byte of the latched active duty value |
| period_tick | output | 1 | High in the first clock of each period |

## Verification
The assertions check on every clock that a rollover clears the timer and raises the tick, that the tick never lasts two cycles, and that the timer steps by exactly one between rollovers. They also check that the active latch holds between rollovers and loads the written value at a rollover, that a zero duty value never lets the output rise, and that a disabled block keeps its output low. Whole-period quantities can only be shown by the bench scenarios: the measured period length for each prescale setting, the high time against D × k, the saturated 0% and 100% cases, and a duty write in the middle of a period that leaves the current pulse width unchanged.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  // Fine bits below the timer in the compare time base.
  localparam int FRAC_W       = 2;
  // Largest prescale exponent (1:16 = 2**4).
  localparam int PS_MAX_SHIFT = 4;
  // Sub-cycle counter width: fine bits plus the largest prescale exponent.
  localparam int SUB_W        = FRAC_W + PS_MAX_SHIFT;

  typedef logic [SUB_W-1:0] sub_t;

  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV4   = 2'b01,
    PS_DIV16  = 2'b10,
    PS_DIV16B = 2'b11
  } presc_e;

  // Prescale exponent: how many sub-counter bits sit below the fine bits.
  function automatic logic [2:0] presc_shift(input logic [1:0] sel);
    case (presc_e'(sel))
      PS_DIV1: presc_shift = 3'd0;
      PS_DIV4: presc_shift = 3'd2;
      default: presc_shift = 3'd4;
    endcase
  endfunction

  // Last sub-counter value before the timer steps: 4*k - 1.
  function automatic sub_t sub_last(input logic [1:0] sel);
    sub_t ones;
    ones = '1;
    sub_last = ones >> (3'(PS_MAX_SHIFT) - presc_shift(sel));
  endfunction

  // Fine time-base bits taken from the sub-counter for the chosen prescale.
  function automatic logic [FRAC_W-1:0] fine_bits(input sub_t sub, input logic [1:0] sel);
    sub_t shifted;
    shifted = sub >> presc_shift(sel);
    fine_bits = shifted[FRAC_W-1:0];
  endfunction

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale
  import pwm_dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        sel,
  output logic              step,
  output logic [FRAC_W-1:0] frac
);

  sub_t sub_q;
  sub_t last_w;

  assign last_w = sub_last(sel);
  // Greater-or-equal so that a change to a finer prescale cannot strand the counter.
  assign step   = en && (sub_q >= last_w);
  assign frac   = fine_bits(sub_q, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sub_q <= '0;
    else if (!en)    sub_q <= '0;
    else if (step)   sub_q <= '0;
    else             sub_q <= sub_q + 1'b1;
  end

  // R1: the sub-cycle counter restarts after each timer step
  assert_step_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (sub_q == '0));

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             step,
  input  logic [TMR_W-1:0] period,
  output logic [TMR_W-1:0] tmr,
  output logic             rollover,
  output logic             tick
);

  logic [TMR_W-1:0] tmr_q;
  logic             tick_q;

  assign rollover = step && (tmr_q == period);
  assign tmr      = tmr_q;
  assign tick     = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= rollover;
      if (!en)           tmr_q <= '0;
      else if (rollover) tmr_q <= '0;
      else if (step)     tmr_q <= tmr_q + 1'b1;
    end
  end

  // R2: rollover clears the timer and raises the tick in the next cycle
  assert_roll_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> (tmr_q == '0 && tick_q));

  // R9: the tick lasts a single cycle
  assert_tick_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  // R1: between rollovers the timer advances by exactly one per step
  assert_timer_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !rollover) |=> (tmr_q == TMR_W'($past(tmr_q) + 1'b1)));

endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int HI_W = 8,
  parameter int LO_W = 2,
  localparam int DW  = HI_W + LO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [HI_W-1:0] duty_hi,
  input  logic [LO_W-1:0] duty_lo,
  output logic [DW-1:0]   active,
  output logic            incoming_nz
);

  logic [DW-1:0] pending_w;
  logic [DW-1:0] active_q;

  assign pending_w   = {duty_hi, duty_lo};
  assign incoming_nz = (pending_w != '0);
  assign active      = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    active_q <= '0;
    else if (load) active_q <= pending_w;
  end

  // R4: the active latch holds between rollovers
  assert_latch_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(active_q));

  // R4: at a rollover the latch takes the written value
  assert_latch_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (active_q == $past({duty_hi, duty_lo})));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
  parameter int TB_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            rollover,
  input  logic            incoming_nz,
  input  logic [TB_W-1:0] active,
  input  logic [TB_W-1:0] tbase,
  output logic            pwm
);

  logic high_q;
  logic match_w;

  assign match_w = (tbase == active);
  // The output falls in the same clock the time base reaches the duty value.
  assign pwm     = high_q && !match_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        high_q <= 1'b0;
    else if (!en)      high_q <= 1'b0;
    else if (rollover) high_q <= incoming_nz;
    else if (match_w)  high_q <= 1'b0;
  end

  // R5: a zero active duty never lets the output rise
  assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> !pwm);

  // R3: a nonzero latched duty starts the period with the output high
  assert_period_starts_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover && incoming_nz) |=> pwm);

endmodule

// File: rtl/pwm_dbuf.sv
module pwm_dbuf
  import pwm_dbuf_pkg::*;
#(
  parameter int TMR_W = 8,
  localparam int DW   = TMR_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       presc_sel,
  input  logic [TMR_W-1:0] period_val,
  input  logic [TMR_W-1:0] duty_hi,
  input  logic [1:0]       duty_lo,
  output logic             pwm_out,
  output logic [TMR_W-1:0] duty_active_hi,
  output logic             period_tick
);

  logic              step_w;
  logic [FRAC_W-1:0] frac_w;
  logic [TMR_W-1:0]  tmr_w;
  logic              rollover_w;
  logic [DW-1:0]     active_w;
  logic              incoming_nz_w;
  logic [DW-1:0]     tbase_w;

  pwm_prescale u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .sel   (presc_sel),
    .step  (step_w),
    .frac  (frac_w)
  );

  pwm_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .step     (step_w),
    .period   (period_val),
    .tmr      (tmr_w),
    .rollover (rollover_w),
    .tick     (period_tick)
  );

  pwm_duty_buf #(.HI_W(TMR_W), .LO_W(FRAC_W)) u_duty (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (rollover_w),
    .duty_hi     (duty_hi),
    .duty_lo     (duty_lo),
    .active      (active_w),
    .incoming_nz (incoming_nz_w)
  );

  assign tbase_w        = {tmr_w, frac_w};
  assign duty_active_hi = active_w[DW-1:FRAC_W];

  pwm_out_stage #(.TB_W(DW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .rollover    (rollover_w),
    .incoming_nz (incoming_nz_w),
    .active      (active_w),
    .tbase       (tbase_w),
    .pwm         (pwm_out)
  );

  // R8: a disabled block holds the timer at zero with the output low
  assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_out && tmr_w == '0));

  // R7: reset state of the outputs
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R7: assert (!pwm_out && !period_tick && duty_active_hi == '0);
    end
  end

endmodule

// File: tb/sim_pwm_dbuf.sv
module sim_pwm_dbuf;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [1:0] presc_sel;
  logic [7:0] period_val;
  logic [7:0] duty_hi;
  logic [1:0] duty_lo;
  logic       pwm_out;
  logic [7:0] duty_active_hi;
  logic       period_tick;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_dbuf u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .presc_sel      (presc_sel),
    .period_val     (period_val),
    .duty_hi        (duty_hi),
    .duty_lo        (duty_lo),
    .pwm_out        (pwm_out),
    .duty_active_hi (duty_active_hi),
    .period_tick    (period_tick)
  );

  function automatic int pre_of(input int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    return 16;
  endfunction

  function automatic int exp_period(input int p, input int sel);
    return (p + 1) * 4 * pre_of(sel);
  endfunction

  function automatic int exp_high(input int p, input int sel, input int d);
    if (d >= 4 * (p + 1)) return exp_period(p, sel);
    return d * pre_of(sel);
  endfunction

  function automatic string tag_of(input int p, input int d);
    if (d == 0) return "R5";
    if (d >= 4 * (p + 1)) return "R6";
    return "R3";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_duty(input int d);
    duty_hi = 8'(d >> 2);
    duty_lo = 2'(d & 3);
  endtask

  // Counts clocks and high clocks up to the next tick; optionally rewrites
  // the duty value at clock index wr_at and records the active byte after it.
  task automatic measure(output int cnt, output int hi, output int mid_act,
                         output int tick2, input int wr_at, input int new_d);
    cnt = 0; hi = 0; mid_act = -1; tick2 = 0;
    do begin
      if (pwm_out) hi++;
      if (cnt == wr_at) set_duty(new_d);
      if (cnt == wr_at + 1) mid_act = int'(duty_active_hi);
      cnt++;
      @(negedge clk);
      if (cnt == 1 && period_tick) tick2 = 1;
    end while (!period_tick && cnt < 20000);
  endtask

  task automatic run_case(input int p, input int sel, input int d);
    int cnt, hi, mid, t2;
    en = 1'b0;
    @(negedge clk); @(negedge clk);
    presc_sel  = 2'(sel);
    period_val = 8'(p);
    set_duty(d);
    en = 1'b1;
    measure(cnt, hi, mid, t2, -5, 0);
    check("R8", "first period high clocks", hi, 0);
    check("R1", "first period length", cnt, exp_period(p, sel));
    check("R4", "latched high byte", int'(duty_active_hi), d >> 2);
    measure(cnt, hi, mid, t2, -5, 0);
    check("R1", "period length", cnt, exp_period(p, sel));
    check(tag_of(p, d), "high clocks", hi, exp_high(p, sel, d));
    check("R9", "tick in second clock", t2, 0);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt, hi, mid, t2, seen_hi, seen_tick;
    void'($urandom(32'd7331));
    rst_n = 1'b0; en = 1'b0; presc_sel = 2'b00;
    period_val = 8'd3; duty_hi = 8'd2; duty_lo = 2'd1;
    repeat (3) @(negedge clk);
    check("R7", "pwm_out in reset", int'(pwm_out), 0);
    check("R7", "period_tick in reset", int'(period_tick), 0);
    check("R7", "duty_active_hi in reset", int'(duty_active_hi), 0);
    rst_n = 1'b1;

    // R8: disabled block stays quiet
    seen_hi = 0; seen_tick = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (pwm_out) seen_hi++;
      if (period_tick) seen_tick++;
    end
    check("R8", "high clocks while disabled", seen_hi, 0);
    check("R8", "ticks while disabled", seen_tick, 0);
    check("R4", "active byte before any rollover", int'(duty_active_hi), 0);

    // Directed corners
    run_case(3, 0, 1);      // R3 finest step: one clock high
    run_case(3, 0, 0);      // R5
    run_case(3, 1, 16);     // R6 exactly one full period
    run_case(2, 2, 60);     // R6 well beyond the period
    run_case(255, 0, 1023); // R3 widest duty at 1:1
    run_case(2, 3, 5);      // R1 select 11 behaves as 1:16
    run_case(4, 0, 2);      // R3 value carried only by the low field

    // R4 double buffering: rewrite the duty in the middle of a period
    run_case(9, 2, 13);
    measure(cnt, hi, mid, t2, 3, 30);
    check("R4", "high clocks after mid-period write", hi, 13 * 16);
    check("R4", "active byte after mid-period write", mid, 13 >> 2);
    check("R4", "active byte at next rollover", int'(duty_active_hi), 30 >> 2);
    measure(cnt, hi, mid, t2, -5, 0);
    check("R4", "high clocks in the following period", hi, 30 * 16);
    check("R2", "period length after rewrite", cnt, exp_period(9, 2));

    // Random mix
    for (int k = 0; k < 14; k++) begin
      int p, sel, d;
      p   = int'($urandom_range(0, 15));
      sel = int'($urandom_range(0, 3));
      d   = int'($urandom_range(0, 4 * (p + 1) + 3));
      run_case(p, sel, d);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule